// File: doc/BRIEF.md
# Video and Graphics Blending Pipeline

This block is a streaming, per-pixel datapath for three colour channels. It merges a main video stream with a low-depth graphics overlay. Main video samples are 10 bits per channel. Each sample is scaled by a contrast gain, shifted by a signed brightness offset, and then passed through a soft clipper with a programmable knee.

Graphics samples are 4 bits per channel. They are first widened to the video width. They then receive their own brightness correction and are limited by a hard clip ceiling.

A 4-bit blend weight travels with each pixel and sets the mix between the two paths in the final stage. The soft-clipped video value that feeds the mixer is also exported with its own valid flag, so that a peak-white measurement can observe it. All settings are static inputs, normally driven from a register bank. Data moves one stage per clock with no stalls.

Top module: `vid_gfx_blend_top`

## Requirements
- R1: A graphics sample is widened from 4 to 10 bits by repeating its bits from the MSB down, giving {g, g, g[3:2]}. 0x0 maps to 0, 0x5 maps to 341, 0xA maps to 682 and 0xF maps to 1023.
- R2: The contrast stage computes floor(video × gain / 128), where gain is an unsigned 8-bit value and 128 means unity. Results above 1023 saturate to 1023.
- R3: Each path adds its own signed 11-bit brightness offset in two's complement. Sums below 0 become 0 and sums above 1023 become 1023.
- R4: The soft clipper passes values at or below the knee unchanged. A value x above the knee becomes knee + floor((x − knee)/2).
- R5: The graphics hard clip outputs min(x, limit), where limit is the 10-bit hard clip input.
- R6: The blended output is floor((a·gfx + (15−a)·video + 7) / 15) for each channel. Here a is the 4-bit blend weight sampled with the pixel, and 0 selects pure video.
- R7: out_valid rises exactly 4 clocks after the in_valid cycle that produced it, and pw_valid rises exactly 3 clocks after. Back-to-back pixels come out on back-to-back cycles.
- R8: pw_rgb carries the soft-clipped video value of each channel, and it is the same value that the blender consumes.
- R9: While rst is high, out_valid and pw_valid are held low and out_rgb and pw_rgb read zero on the next clock.
- R10: Channels are processed independently. Channel k occupies bits [10k+9:10k] of the 10-bit buses and bits [4k+3:4k] of gfx_rgb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks a pixel on the input buses |
| vid_rgb | input | 30 | Main video, three 10-bit channels |
| gfx_rgb | input | 12 | Graphics overlay, three 4-bit channels |
| alpha | input | 4 | Per-pixel blend weight, 0 = video, 15 = graphics |
| contrast_gain | input | 8 | Unsigned video gain, 1.7 fixed point |
| vid_offset | input | 11 | Signed brightness offset for video |
| knee | input | 10 | Soft clip knee level |
| gfx_offset | input | 11 | Signed brightness offset for graphics |
| hard_limit | input | 10 | Graphics hard clip ceiling |
| out_valid | output | 1 | Blended pixel valid |
| out_rgb | output | 30 | Blended pixel, three 10-bit channels |
| pw_valid | output | 1 | Peak-white tap valid |
| pw_rgb | output | 30 | Video as it enters the blender |

## Verification
A stuck or mis-wired stage in either path shows up on out_rgb four cycles after the pixel enters. The video half can be isolated one cycle earlier on pw_rgb, so a fault there can be traced to the main path or to the mixer. Vectors with the weight at 0 or 15 expose each path on its own. Intermediate weights expose rounding or weighting errors in the mixer. A broken valid chain or an unaligned weight delay shows as a valid pulse one cycle off, or as a blend of neighbouring pixels in the back-to-back run.

// File: rtl/vgb_pkg.sv
package vgb_pkg;
  localparam int PIX_W   = 10;
  localparam int OFF_W   = PIX_W + 1;
  localparam int PIX_MAX = (1 << PIX_W) - 1;

  // Add a signed offset to an unsigned pixel and clamp to 0..PIX_MAX
  function automatic logic [PIX_W-1:0] add_clamp(input logic [PIX_W-1:0] p,
                                                  input logic [OFF_W-1:0] off);
    logic signed [PIX_W+1:0] s;
    s = $signed({2'b00, p}) + $signed({off[OFF_W-1], off});
    if (s < 0)
      return '0;
    else if (s > $signed((PIX_W+2)'(PIX_MAX)))
      return PIX_W'(PIX_MAX);
    else
      return s[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/vid_lane.sv
module vid_lane
  import vgb_pkg::*;
#(
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PIX_W-1:0]  pix_in,
  input  logic [GAIN_W-1:0] gain,
  input  logic [OFF_W-1:0]  offset,
  input  logic [PIX_W-1:0]  knee,
  output logic [PIX_W-1:0]  pix_out
);
  localparam int PROD_W = PIX_W + GAIN_W;

  logic [PROD_W-1:0] prod, prod_sh;
  logic [PIX_W-1:0]  gain_sat;
  logic [PIX_W-1:0]  st_con, st_bri;
  logic [PIX_W-1:0]  soft_val;

  always_comb begin
    prod    = PROD_W'(pix_in) * PROD_W'(gain);
    prod_sh = prod >> GAIN_FRAC;
    if (|prod_sh[PROD_W-1:PIX_W])
      gain_sat = PIX_W'(PIX_MAX);
    else
      gain_sat = prod_sh[PIX_W-1:0];
  end

  always_comb begin
    if (st_bri > knee)
      soft_val = knee + ((st_bri - knee) >> 1);
    else
      soft_val = st_bri;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_con  <= '0;
      st_bri  <= '0;
      pix_out <= '0;
    end else begin
      st_con  <= gain_sat;
      st_bri  <= add_clamp(st_con, offset);
      pix_out <= soft_val;
    end
  end
endmodule

// File: rtl/gfx_lane.sv
module gfx_lane
  import vgb_pkg::*;
#(
  parameter int GFX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [GFX_W-1:0] pix_in,
  input  logic [OFF_W-1:0] offset,
  input  logic [PIX_W-1:0] limit,
  output logic [PIX_W-1:0] pix_out
);
  logic [PIX_W-1:0] wide;
  logic [PIX_W-1:0] st_wide, st_bri;

  // Replicate source bits from the MSB downward to fill the full width
  for (genvar i = 0; i < PIX_W; i++) begin : g_rep
    assign wide[PIX_W-1-i] = pix_in[GFX_W-1-(i % GFX_W)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_wide <= '0;
      st_bri  <= '0;
      pix_out <= '0;
    end else begin
      st_wide <= wide;
      st_bri  <= add_clamp(st_wide, offset);
      pix_out <= (st_bri > limit) ? limit : st_bri;
    end
  end
endmodule

// File: rtl/blend_lane.sv
module blend_lane
  import vgb_pkg::*;
#(
  parameter int ALPHA_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ALPHA_W-1:0] weight,
  input  logic [PIX_W-1:0]   vid,
  input  logic [PIX_W-1:0]   gfx,
  output logic [PIX_W-1:0]   pix_out
);
  localparam int AMAX  = (1 << ALPHA_W) - 1;
  localparam int ACC_W = PIX_W + ALPHA_W + 1;

  logic [ACC_W-1:0] acc, quo;

  always_comb begin
    acc = ACC_W'(weight) * ACC_W'(gfx)
        + ACC_W'(AMAX - int'(weight)) * ACC_W'(vid)
        + ACC_W'(AMAX / 2);
    quo = acc / ACC_W'(AMAX);
  end

  always_ff @(posedge clk) begin
    if (rst) pix_out <= '0;
    else     pix_out <= quo[PIX_W-1:0];
  end
endmodule

// File: rtl/vid_gfx_blend_top.sv
module vid_gfx_blend_top
  import vgb_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int GFX_W     = 4,
  parameter int ALPHA_W   = 4,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [NUM_CH*PIX_W-1:0] vid_rgb,
  input  logic [NUM_CH*GFX_W-1:0] gfx_rgb,
  input  logic [ALPHA_W-1:0]      alpha,
  input  logic [GAIN_W-1:0]       contrast_gain,
  input  logic [OFF_W-1:0]        vid_offset,
  input  logic [PIX_W-1:0]        knee,
  input  logic [OFF_W-1:0]        gfx_offset,
  input  logic [PIX_W-1:0]        hard_limit,
  output logic                    out_valid,
  output logic [NUM_CH*PIX_W-1:0] out_rgb,
  output logic                    pw_valid,
  output logic [NUM_CH*PIX_W-1:0] pw_rgb
);
  localparam int PATH_STAGES = 3;

  logic [PATH_STAGES-1:0] vld_sr;
  logic [ALPHA_W-1:0]     alpha_sr [PATH_STAGES];
  logic [NUM_CH*PIX_W-1:0] gfx_clip;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_sr    <= '0;
      out_valid <= 1'b0;
      for (int s = 0; s < PATH_STAGES; s++) alpha_sr[s] <= '0;
    end else begin
      vld_sr      <= {vld_sr[PATH_STAGES-2:0], in_valid};
      out_valid   <= vld_sr[PATH_STAGES-1];
      alpha_sr[0] <= alpha;
      for (int s = 1; s < PATH_STAGES; s++) alpha_sr[s] <= alpha_sr[s-1];
    end
  end

  assign pw_valid = vld_sr[PATH_STAGES-1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    vid_lane #(.GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)) u_vid (
      .clk    (clk),
      .rst    (rst),
      .pix_in (vid_rgb[c*PIX_W +: PIX_W]),
      .gain   (contrast_gain),
      .offset (vid_offset),
      .knee   (knee),
      .pix_out(pw_rgb[c*PIX_W +: PIX_W])
    );

    gfx_lane #(.GFX_W(GFX_W)) u_gfx (
      .clk    (clk),
      .rst    (rst),
      .pix_in (gfx_rgb[c*GFX_W +: GFX_W]),
      .offset (gfx_offset),
      .limit  (hard_limit),
      .pix_out(gfx_clip[c*PIX_W +: PIX_W])
    );

    blend_lane #(.ALPHA_W(ALPHA_W)) u_mix (
      .clk    (clk),
      .rst    (rst),
      .weight (alpha_sr[PATH_STAGES-1]),
      .vid    (pw_rgb[c*PIX_W +: PIX_W]),
      .gfx    (gfx_clip[c*PIX_W +: PIX_W]),
      .pix_out(out_rgb[c*PIX_W +: PIX_W])
    );
  end
endmodule

// File: rtl/vgb_checker.sv
module vgb_checker
  import vgb_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic [PIX_W-1:0]        knee,
  input logic [PIX_W-1:0]        hard_limit,
  input logic                    out_valid,
  input logic [NUM_CH*PIX_W-1:0] out_rgb,
  input logic                    pw_valid,
  input logic [NUM_CH*PIX_W-1:0] pw_rgb
);
  logic [2:0]             run_cnt;
  logic [3:0]             in_hist;
  logic [PIX_W-1:0]       knee_d1, lim_d1, lim_d2;
  logic [NUM_CH*PIX_W-1:0] pw_d1;

  always_ff @(posedge clk) begin
    if (rst) run_cnt <= '0;
    else if (run_cnt != 3'd7) run_cnt <= run_cnt + 3'd1;
    in_hist <= {in_hist[2:0], in_valid};
    knee_d1 <= knee;
    lim_d1  <= hard_limit;
    lim_d2  <= lim_d1;
    pw_d1   <= pw_rgb;
  end

  // R7
  out_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (run_cnt >= 3'd4) |-> (out_valid == in_hist[3]));

  // R7
  pw_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (run_cnt >= 3'd3) |-> (pw_valid == in_hist[2]));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !pw_valid && out_rgb == '0 && pw_rgb == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    logic [PIX_W:0] pw_c, knee_c, above, headroom, bound, out_c;
    assign pw_c     = {1'b0, pw_rgb[c*PIX_W +: PIX_W]};
    assign knee_c   = {1'b0, knee_d1};
    assign above    = pw_c - knee_c;
    assign headroom = (PIX_W+1)'(PIX_MAX) - knee_c;
    assign out_c    = {1'b0, out_rgb[c*PIX_W +: PIX_W]};
    assign bound    = (pw_d1[c*PIX_W +: PIX_W] > lim_d2) ?
                      {1'b0, pw_d1[c*PIX_W +: PIX_W]} : {1'b0, lim_d2};

    // R4
    soft_knee_chk: assert property (@(posedge clk) disable iff (rst)
      (run_cnt >= 3'd1 && pw_valid && pw_c > knee_c) |-> ((above << 1) <= headroom));

    // R6
    blend_bound_chk: assert property (@(posedge clk) disable iff (rst)
      (run_cnt >= 3'd2 && out_valid) |-> (out_c <= bound));
  end
endmodule

bind vid_gfx_blend_top vgb_checker #(.NUM_CH(NUM_CH)) u_vgb_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .knee      (knee),
  .hard_limit(hard_limit),
  .out_valid (out_valid),
  .out_rgb   (out_rgb),
  .pw_valid  (pw_valid),
  .pw_rgb    (pw_rgb)
);

// File: tb/tb_vid_gfx_blend_top.sv
`timescale 1ns/1ps
module tb_vid_gfx_blend_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [29:0] vid_rgb;
  logic [11:0] gfx_rgb;
  logic [3:0]  alpha;
  logic [7:0]  contrast_gain;
  logic [10:0] vid_offset;
  logic [9:0]  knee;
  logic [10:0] gfx_offset;
  logic [9:0]  hard_limit;
  logic        out_valid;
  logic [29:0] out_rgb;
  logic        pw_valid;
  logic [29:0] pw_rgb;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  vid_gfx_blend_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .vid_rgb(vid_rgb),
    .gfx_rgb(gfx_rgb), .alpha(alpha), .contrast_gain(contrast_gain),
    .vid_offset(vid_offset), .knee(knee), .gfx_offset(gfx_offset),
    .hard_limit(hard_limit), .out_valid(out_valid), .out_rgb(out_rgb),
    .pw_valid(pw_valid), .pw_rgb(pw_rgb)
  );

  typedef struct packed {
    logic [29:0] vid;
    logic [11:0] gfx;
    logic [3:0]  a;
    logic [7:0]  gain;
    logic [10:0] voff;
    logic [9:0]  kn;
    logic [10:0] goff;
    logic [9:0]  lim;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{ {10'd300, 10'd200, 10'd100}, 12'h000, 4'd0,  8'd128, 11'd0,    10'd1023, 11'd0,   10'd1023 },
    '{ {10'd600, 10'd100, 10'd600}, 12'h000, 4'd0,  8'd255, 11'd0,    10'd1023, 11'd0,   10'd1023 },
    '{ {10'd301, 10'd900, 10'd50},  12'h000, 4'd0,  8'd64,  -11'sd200, 10'd1023, 11'd0,   10'd1023 },
    '{ {10'd1000, 10'd400, 10'd700}, 12'h000, 4'd0, 8'd128, 11'd0,    10'd512,  11'd0,   10'd1023 },
    '{ {10'd10, 10'd20, 10'd30},    12'hA5F, 4'd15, 8'd128, 11'd0,    10'd1023, 11'd0,   10'd1023 },
    '{ {10'd10, 10'd20, 10'd30},    12'h08F, 4'd15, 8'd128, 11'd0,    10'd1023, 11'd100, 10'd700  },
    '{ {10'd1000, 10'd1000, 10'd1000}, 12'h000, 4'd7, 8'd128, 11'd0,  10'd1023, 11'd0,   10'd1023 },
    '{ {10'd0, 10'd500, 10'd0},     12'h0FF, 4'd1,  8'd140, 11'd1000, 10'd800, -11'sd50, 10'd900  }
  };

  function automatic int clamp(input int x);
    return (x < 0) ? 0 : (x > 1023) ? 1023 : x;
  endfunction

  function automatic int ref_vid(input int v, input int g, input int off, input int kn);
    int c;
    c = clamp((v * g) / 128);
    c = clamp(c + off);
    if (c > kn) c = kn + (c - kn) / 2;
    return c;
  endfunction

  function automatic int ref_gfx(input int g4, input int off, input int lim);
    int w;
    w = (g4 << 6) | (g4 << 2) | (g4 >> 2);
    w = clamp(w + off);
    return (w > lim) ? lim : w;
  endfunction

  function automatic int ref_mix(input int a, input int v, input int g);
    return (a * g + (15 - a) * v + 7) / 15;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    vid_rgb       = v.vid;
    gfx_rgb       = v.gfx;
    alpha         = v.a;
    contrast_gain = v.gain;
    vid_offset    = v.voff;
    knee          = v.kn;
    gfx_offset    = v.goff;
    hard_limit    = v.lim;
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1;
    in_valid = 1'b0;
    apply(VEC[0]);
    repeat (3) @(negedge clk);
    // R9: state after reset
    check("R9 out_valid", int'(out_valid), 0);
    check("R9 pw_valid", int'(pw_valid), 0);
    check("R9 out_rgb", int'(out_rgb), 0);
    check("R9 pw_rgb", int'(pw_rgb), 0);
    rst = 1'b0;

    // Vector table: R1 R2 R3 R4 R5 R6 R8 R10
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VEC[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      check("R7 pw early", int'(pw_valid), 0);
      @(negedge clk);
      check("R7 pw_valid", int'(pw_valid), 1);
      check("R7 out early", int'(out_valid), 0);
      for (int c = 0; c < 3; c++)
        check("R8 R2 R3 R4 pw", int'(pw_rgb[c*10 +: 10]),
              ref_vid(int'(VEC[i].vid[c*10 +: 10]), int'(VEC[i].gain),
                      int'($signed(VEC[i].voff)), int'(VEC[i].kn)));
      @(negedge clk);
      check("R7 out_valid", int'(out_valid), 1);
      for (int c = 0; c < 3; c++) begin
        int ev, eg;
        ev = ref_vid(int'(VEC[i].vid[c*10 +: 10]), int'(VEC[i].gain),
                     int'($signed(VEC[i].voff)), int'(VEC[i].kn));
        eg = ref_gfx(int'(VEC[i].gfx[c*4 +: 4]), int'($signed(VEC[i].goff)),
                     int'(VEC[i].lim));
        check("R6 R1 R5 R10 out", int'(out_rgb[c*10 +: 10]), ref_mix(int'(VEC[i].a), ev, eg));
      end
    end

    // R1: widening of 0x5, 0xA, 0xF at full weight
    @(negedge clk);
    apply(VEC[4]);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 0xF", int'(out_rgb[9:0]), 1023);
    check("R1 0x5", int'(out_rgb[19:10]), 341);
    check("R1 0xA", int'(out_rgb[29:20]), 682);

    // R5: hard clip at 700 for 0xF graphics
    @(negedge clk);
    apply(VEC[5]);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R5 clip", int'(out_rgb[9:0]), 700);

    // R7 R6: three back-to-back pixels, weights 0, 15, 8
    @(negedge clk);
    apply(VEC[0]);
    gfx_rgb = 12'hFFF;
    for (int p = 0; p < 3; p++) begin
      alpha = (p == 0) ? 4'd0 : (p == 1) ? 4'd15 : 4'd8;
      in_valid = 1'b1;
      @(negedge clk);
    end
    in_valid = 1'b0;
    @(negedge clk);
    check("R7 stream p0 valid", int'(out_valid), 1);
    check("R6 stream p0", int'(out_rgb[9:0]), 100);
    @(negedge clk);
    check("R7 stream p1 valid", int'(out_valid), 1);
    check("R6 stream p1", int'(out_rgb[9:0]), 1023);
    @(negedge clk);
    check("R7 stream p2 valid", int'(out_valid), 1);
    check("R6 stream p2", int'(out_rgb[9:0]), ref_mix(8, 100, 1023));
    @(negedge clk);
    check("R7 stream end", int'(out_valid), 0);

    // R9: reset in the middle of a pixel flight
    apply(VEC[1]);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 mid pw_valid", int'(pw_valid), 0);
    check("R9 mid out_rgb", int'(out_rgb), 0);
    repeat (3) @(negedge clk);
    check("R9 no late valid", int'(out_valid), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule